// File: doc/BRIEF.md
# Dual-Region External Bus Wait-State Generator

This block turns a CPU-side memory request into an external bus cycle with an address phase and a data phase. Each phase can be stretched by a programmable number of wait cycles, counted on the internal bus clock. One address bit splits the external space into a lower and an upper region. Each region has its own data-phase stretch and its own active-low data strobe, so a slow memory and a fast memory can sit side by side. Only upper-region cycles get the extra address-phase stretch.

Two 8-bit configuration registers are written and read through a simple register port. Select 0 is the wait-control register. Select 1 is the address-stretch register, and it cannot be changed while the interrupt-service flag is high. The requester holds its request until the block returns a one-cycle ready pulse, which carries the read data on reads.

Top module: `xbus_wait_gen`

## Requirements
- R1: After reset, the wait-control register (select 0) reads 7Fh, the address-stretch register (select 1) reads 03h, all strobes are high and ready is low.
- R2: Wait-control layout: bit 7 always reads 0; bit 6 is an enable flag; bits 5:3 are the upper data stretch; bits 2:0 are the lower data stretch. Bits 6:0 read back exactly as written.
- R3: Address bit 21 selects the region. When it is 1, only `bus_ds_hi_n` pulses low. When it is 0, only `bus_ds_lo_n` pulses low.
- R4: The address strobe is low for 1 + S cycles, where S is the 2-bit stretch in bits 1:0 of the address-stretch register for upper cycles, and S is 0 for lower cycles.
- R5: The selected data strobe is low for 1 + the region's 3-bit data stretch, so a stretch of 0 gives one cycle and 7 gives eight.
- R6: A write to the address-stretch register while `isr_active` is high leaves it unchanged. When `isr_active` is low, the write stores bits 1:0. Bits 7:2 of this register read 0.
- R7: Stretch values are sampled when a request is accepted. A register write during a cycle affects only later cycles.
- R8: Ready is high for exactly one cycle, the cycle after the data phase. Total latency from acceptance is address length + data length + 1. Read data sampled in the last data cycle appears on `req_rdata` with ready. On writes, `bus_we` is high and `bus_wdata` holds the write data while the data strobe is low.
- R9: In idle all strobes are high, and the address strobe is never low together with a data strobe. `bus_addr` holds the request address throughout the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal bus clock |
| rst | input | 1 | synchronous active-high reset |
| isr_active | input | 1 | interrupt-service flag; blocks address-stretch writes |
| cfg_we | input | 1 | register write strobe |
| cfg_sel | input | 1 | register select: 0 wait-control, 1 address-stretch |
| cfg_wdata | input | 8 | register write data |
| cfg_rdata | output | 8 | read value of the selected register |
| req_valid | input | 1 | request valid, held until ready |
| req_addr | input | 22 | request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | write data |
| req_ready | output | 1 | one-cycle completion pulse |
| req_rdata | output | 8 | read data, valid with ready |
| bus_addr | output | 22 | external address |
| bus_wdata | output | 8 | external write data |
| bus_we | output | 1 | write-enable, high during a write data phase |
| bus_rdata | input | 8 | external read data |
| bus_as_n | output | 1 | address strobe, active low |
| bus_ds_hi_n | output | 1 | upper-region data strobe, active low |
| bus_ds_lo_n | output | 1 | lower-region data strobe, active low |

## Verification
Directed cycles run with reset stretches, with all stretches at zero, and under an interrupt-flag write. Together they show the maximum and minimum phase lengths, and show that a blocked write really changes nothing. One cycle has a register write landing mid-cycle; comparing it with the cycle that follows shows when stretch values are sampled. Random mixes of register writes, with random interrupt flags, and random reads and writes to both regions show whether region decode, strobe selection and per-region stretch stay separate across all field values.

// File: rtl/xbw_pkg.sv
package xbw_pkg;

    localparam int REG_W     = 8;
    localparam int AS_STR_W  = 2;
    localparam int DS_STR_W  = 3;
    localparam int CNT_W     = (DS_STR_W > AS_STR_W) ? DS_STR_W : AS_STR_W;

    localparam logic [REG_W-2:0]    WC_RST = 7'h7F;
    localparam logic [AS_STR_W-1:0] AS_RST = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic [AS_STR_W-1:0] as_up;
        logic [DS_STR_W-1:0] ds_up;
        logic [DS_STR_W-1:0] ds_lo;
    } wait_cfg_t;

    function automatic logic [CNT_W-1:0] as_count(input wait_cfg_t c, input logic upper);
        return upper ? CNT_W'(c.as_up) : '0;
    endfunction

    function automatic logic [CNT_W-1:0] ds_count(input wait_cfg_t c, input logic upper);
        return upper ? CNT_W'(c.ds_up) : CNT_W'(c.ds_lo);
    endfunction

endpackage

// File: rtl/xbw_cfg_regs.sv
module xbw_cfg_regs
    import xbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             isr_active,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output wait_cfg_t        cfg
);

    logic [REG_W-2:0]    wc_q;
    logic [AS_STR_W-1:0] as_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wc_q <= WC_RST;
            as_q <= AS_RST;
        end else if (cfg_we) begin
            if (!cfg_sel)
                wc_q <= cfg_wdata[REG_W-2:0];
            else if (!isr_active)
                as_q <= cfg_wdata[AS_STR_W-1:0];
        end
    end

    always_comb begin
        cfg.as_up = as_q;
        cfg.ds_up = wc_q[2*DS_STR_W-1:DS_STR_W];
        cfg.ds_lo = wc_q[DS_STR_W-1:0];
        cfg_rdata = cfg_sel ? {{(REG_W-AS_STR_W){1'b0}}, as_q} : {1'b0, wc_q};
    end

    // R1: first cycle out of reset shows the reset stretches
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg.ds_up == 3'd7 && cfg.ds_lo == 3'd7 && cfg.as_up == 2'd3));

    // R2: wait-control write lands in the data stretch fields
    assert_wc_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_sel) |=> (cfg.ds_up == $past(cfg_wdata[5:3]) && cfg.ds_lo == $past(cfg_wdata[2:0])));

    // R6: interrupt flag blocks address-stretch writes
    assert_isr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel && isr_active) |=> $stable(cfg.as_up));

endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
    import xbw_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 8,
    parameter int REGION_BIT = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  wait_cfg_t         cfg,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_as_n,
    output logic              bus_ds_hi_n,
    output logic              bus_ds_lo_n
);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  ds_str_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              write_q;
    logic              upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            ds_str_q <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            write_q  <= 1'b0;
            upper_q  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    write_q  <= req_write;
                    wdata_q  <= req_wdata;
                    upper_q  <= req_addr[REGION_BIT];
                    cnt      <= as_count(cfg, req_addr[REGION_BIT]);
                    ds_str_q <= ds_count(cfg, req_addr[REGION_BIT]);
                    phase    <= PH_ADDR;
                end
                PH_ADDR: if (cnt == '0) begin
                    cnt   <= ds_str_q;
                    phase <= PH_DATA;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_DATA: if (cnt == '0) begin
                    if (!write_q)
                        rdata_q <= bus_rdata;
                    phase <= PH_DONE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_as_n    = (phase != PH_ADDR);
        bus_ds_hi_n = !(phase == PH_DATA && upper_q);
        bus_ds_lo_n = !(phase == PH_DATA && !upper_q);
        bus_we      = (phase == PH_DATA) && write_q;
        bus_addr    = addr_q;
        bus_wdata   = wdata_q;
        req_ready   = (phase == PH_DONE);
        req_rdata   = rdata_q;
    end

    // R3: upper strobe only for upper addresses, lower strobe only for lower
    assert_hi_region_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_ds_hi_n |-> bus_addr[REGION_BIT]);
    assert_lo_region_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_ds_lo_n |-> !bus_addr[REGION_BIT]);

    // R4: lower-region address strobe lasts one cycle
    assert_lo_as_len_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_as_n) && !bus_addr[REGION_BIT]) |=> bus_as_n);

    // R8: ready is a single-cycle pulse
    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R9: address and data strobes never overlap
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(!bus_as_n && (!bus_ds_hi_n || !bus_ds_lo_n)));

endmodule

// File: rtl/xbus_wait_gen.sv
module xbus_wait_gen
    import xbw_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 8,
    parameter int REGION_BIT = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              isr_active,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_as_n,
    output logic              bus_ds_hi_n,
    output logic              bus_ds_lo_n
);

    wait_cfg_t cfg;

    xbw_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .isr_active (isr_active),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg        (cfg)
    );

    xbw_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .REGION_BIT (REGION_BIT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .req_rdata   (req_rdata),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .bus_as_n    (bus_as_n),
        .bus_ds_hi_n (bus_ds_hi_n),
        .bus_ds_lo_n (bus_ds_lo_n)
    );

endmodule

// File: tb/test_xbus_wait_gen.sv
module test_xbus_wait_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          isr_active = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [7:0]    req_wdata = '0;
    logic          req_ready;
    logic [7:0]    req_rdata;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_we;
    logic [7:0]    bus_rdata;
    logic          bus_as_n, bus_ds_hi_n, bus_ds_lo_n;

    int n_checks = 0;
    int n_errors = 0;

    logic [6:0] exp_wc = 7'h7F;
    logic [1:0] exp_as = 2'd3;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory stub: read value derived from the address
    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    xbus_wait_gen i_xbus_wait_gen (
        .clk(clk), .rst(rst), .isr_active(isr_active),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .bus_as_n(bus_as_n), .bus_ds_hi_n(bus_ds_hi_n), .bus_ds_lo_n(bus_ds_lo_n)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_as_len(input logic upper);
        return 1 + (upper ? int'(exp_as) : 0);
    endfunction

    function automatic int exp_ds_len(input logic upper);
        return 1 + (upper ? int'(exp_wc[5:3]) : int'(exp_wc[2:0]));
    endfunction

    task automatic reg_write(input logic sel, input logic [7:0] d, input logic isr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; isr_active = isr;
        if (!sel) exp_wc = d[6:0];
        else if (!isr) exp_as = d[1:0];
        @(negedge clk);
        cfg_we = 1'b0; isr_active = 1'b0;
    endtask

    task automatic reg_check(input logic sel, input string tag);
        logic [7:0] e;
        @(negedge clk);
        cfg_sel = sel;
        #1;
        e = sel ? {6'd0, exp_as} : {1'b0, exp_wc};
        check(cfg_rdata == e, tag, cfg_rdata, e);
    endtask

    task automatic do_access(input logic [AW-1:0] a, input logic wr, input logic [7:0] wd);
        logic up;
        int e_as, e_ds, cyc, n_as, n_hi, n_lo, bad_wr, bad_ovl, bad_addr;
        up = a[21];
        e_as = exp_as_len(up);
        e_ds = exp_ds_len(up);
        cyc = 0; n_as = 0; n_hi = 0; n_lo = 0; bad_wr = 0; bad_ovl = 0; bad_addr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
        do begin
            @(negedge clk);
            cyc++;
            if (!bus_as_n) n_as++;
            if (!bus_ds_hi_n) n_hi++;
            if (!bus_ds_lo_n) n_lo++;
            if (!bus_as_n && (!bus_ds_hi_n || !bus_ds_lo_n)) bad_ovl++;
            if ((!bus_as_n || !bus_ds_hi_n || !bus_ds_lo_n) && bus_addr != a) bad_addr++;
            if ((!bus_ds_hi_n || !bus_ds_lo_n) && (bus_we != wr || (wr && bus_wdata != wd))) bad_wr++;
        end while (!req_ready && cyc < 40);
        if (!wr)
            check(req_rdata == (a[7:0] ^ 8'hA5), "R8 read data", req_rdata, a[7:0] ^ 8'hA5);
        req_valid = 1'b0;
        check(n_as == e_as, "R4 address strobe length", n_as, e_as);
        check((up ? n_hi : n_lo) == e_ds, "R5 data strobe length", up ? n_hi : n_lo, e_ds);
        check((up ? n_lo : n_hi) == 0, "R3 wrong region strobe", up ? n_lo : n_hi, 0);
        check(cyc == e_as + e_ds + 1, "R8 latency", cyc, e_as + e_ds + 1);
        check(bad_wr == 0, "R8 write drive", bad_wr, 0);
        check(bad_ovl == 0 && bad_addr == 0, "R9 overlap or address", bad_ovl + bad_addr, 0);
        @(negedge clk);
        check(bus_as_n && bus_ds_hi_n && bus_ds_lo_n && !req_ready, "R9 idle strobes",
              {bus_as_n, bus_ds_hi_n, bus_ds_lo_n, req_ready}, 4'b1110);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check(bus_as_n && bus_ds_hi_n && bus_ds_lo_n && !req_ready, "R1 strobes after reset",
              {bus_as_n, bus_ds_hi_n, bus_ds_lo_n, req_ready}, 4'b1110);
        reg_check(1'b0, "R1 wait-control reset");
        reg_check(1'b1, "R1 address-stretch reset");

        // maximum stretches, both regions
        do_access(22'h200013, 1'b0, 8'h00);
        do_access(22'h000044, 1'b1, 8'h3C);

        // R2 bit 7 reads zero, other bits kept
        reg_write(1'b0, 8'hFF, 1'b0);
        reg_check(1'b0, "R2 bit7 zero");
        reg_write(1'b0, 8'h92, 1'b0);
        reg_check(1'b0, "R2 readback");
        do_access(22'h3FFF01, 1'b0, 8'h00);
        do_access(22'h1FFFFF, 1'b0, 8'h00);

        // R6 blocked and accepted address-stretch writes
        reg_write(1'b1, 8'h00, 1'b1);
        reg_check(1'b1, "R6 blocked write");
        do_access(22'h200100, 1'b0, 8'h00);
        reg_write(1'b1, 8'hFD, 1'b0);
        reg_check(1'b1, "R6 accepted write");

        // zero stretches
        reg_write(1'b0, 8'h00, 1'b0);
        reg_write(1'b1, 8'h00, 1'b0);
        do_access(22'h2000AA, 1'b1, 8'h81);
        do_access(22'h000055, 1'b0, 8'h00);

        // R7 write lands during an access
        reg_write(1'b1, 8'h02, 1'b0);
        reg_write(1'b0, 8'h28, 1'b0);
        fork
            do_access(22'h3000F0, 1'b0, 8'h00);
            begin
                repeat (2) @(negedge clk);
                reg_write(1'b0, 8'h00, 1'b0);
            end
        join
        check(exp_wc == 7'h00, "R7 shadow updated", exp_wc, 0);
        do_access(22'h3000F1, 1'b0, 8'h00);

        // random mix
        for (int i = 0; i < 60; i++) begin
            if ($urandom % 3 == 0)
                reg_write(1'($urandom % 2), 8'($urandom), 1'($urandom % 2));
            do_access(AW'($urandom), 1'($urandom % 2), 8'($urandom));
        end
        reg_check(1'b0, "R2 final readback");
        reg_check(1'b1, "R6 final readback");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule